// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit sits beside the decode stage of a thread-interleaved pipeline and gives every hardware thread its own countdown timer. A deadline instruction states how long the next block of code must take. When the instruction is decoded and the thread's timer is still running, the unit stalls the thread so that the pipeline replays the same instruction on the thread's next turn. When the timer reads zero, the instruction completes and re-arms the timer with the new duration. The duration comes either from an immediate field or from a register operand that the decode stage supplies.

Timers count down by one each time their thread's slot comes round, which a tick strobe with a thread id signals. Branching forms of the instruction also check whether the deadline was already missed. A miss means the thread arrived at the instruction after its timer had run out, without having waited for it. In that case the unit raises an exception that carries the handler target from the instruction, and the timer is still re-armed. The stall and exception outputs are combinational, so the replay decision is made in the decode cycle.

Top module: `deadline_timer_unit`

## Requirements
- R1: When `dl_valid` is high with a thread id below NUM_THREADS and that thread's timer is nonzero, `stall` is high in the same cycle and the timer is not reloaded.
- R2: When `dl_valid` is high with a valid thread id and that thread's timer is zero, `stall` is low and the timer holds the new duration after the next clock edge.
- R3: `dl_op` encoding: 2'b00 loads the immediate, 2'b01 loads the register operand, 2'b10 is the branching form with the immediate, and 2'b11 is the branching form with the register operand. Bit 0 selects the source and bit 1 marks the branching form.
- R4: A `tick` with `tick_tid` equal to a thread lowers that thread's timer by one. A timer at zero stays at zero.
- R5: When a reload and a tick hit the same thread in the same cycle, the reload wins and the timer holds exactly the new duration.
- R6: A branching form that completes raises `exc_valid`, with `exc_target` equal to `dl_handler`, in the same cycle when three conditions hold: the thread did not stall on a deadline instruction since its last reload, the timer is zero, and the number of ticks seen at zero is at least GRACE (default 0). At all other times `exc_target` is zero.
- R7: A branching form that reached zero by stalling raises no exception. A non-branching form never raises one.
- R8: A thread id of NUM_THREADS or above on the instruction side produces no stall, no exception and no timer change. A tick with such an id changes no timer.
- R9: After reset every timer is zero and no thread is marked as having waited. `stall` and `exc_valid` are low while `dl_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | A thread's scheduling slot came round |
| tick_tid | input | 3 | Thread whose slot the tick marks |
| dl_valid | input | 1 | A deadline instruction is decoded this cycle |
| dl_tid | input | 3 | Thread issuing the instruction |
| dl_op | input | 2 | Instruction form (R3) |
| dl_imm | input | 32 | Immediate duration |
| dl_reg | input | 32 | Register-operand duration |
| dl_handler | input | 32 | Handler target for a missed deadline |
| stall | output | 1 | Replay the instruction on the thread's next turn |
| exc_valid | output | 1 | Missed-deadline exception raised |
| exc_target | output | 32 | Handler target while `exc_valid` is high, else zero |

## Verification
A table of instructions drives the main function through four patterns. Arriving at a timer that is already zero separates a clean reload from a stall. Arriving at a running timer counts how many replay cycles are needed, which shows both the decrement and the tick-versus-reload precedence. Pre-ticking a timer past zero before a branching form separates a true miss from a thread that waited its turn. Switching between the immediate and register operands, with distinct values in each field, shows which source was loaded. Directed cases then cover the reset state, thread ids that are out of range on both the tick side and the instruction side, and the highest valid thread.

// File: rtl/dtu_pkg.sv
`timescale 1ns/1ps
package dtu_pkg;
  typedef enum logic [1:0] {
    DL_IMM    = 2'b00,
    DL_REG    = 2'b01,
    DL_BR_IMM = 2'b10,
    DL_BR_REG = 2'b11
  } dl_op_e;

  localparam int unsigned DTU_THREADS = 6;
  localparam int unsigned DTU_TID_W   = 3;
  localparam int unsigned DTU_TIMER_W = 32;
  localparam int unsigned DTU_ADDR_W  = 32;
  localparam int unsigned DTU_OVR_W   = 4;
endpackage

// File: rtl/dtu_thread_slot.sv
`timescale 1ns/1ps
module dtu_thread_slot #(
  parameter int unsigned TIMER_W = 32,
  parameter int unsigned OVR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_hit,
  input  logic               load_en,
  input  logic [TIMER_W-1:0] load_val,
  input  logic               wait_set,
  output logic [TIMER_W-1:0] timer_o,
  output logic               waited_o,
  output logic [OVR_W-1:0]   over_o
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  function automatic logic [TIMER_W-1:0] count_down(input logic [TIMER_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [OVR_W-1:0] over_step(input logic [OVR_W-1:0] v);
    return (v == OVR_MAX) ? v : v + 1'b1;
  endfunction

  logic [TIMER_W-1:0] timer_q;
  logic               waited_q;
  logic [OVR_W-1:0]   over_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q  <= '0;
      waited_q <= 1'b0;
      over_q   <= '0;
    end else if (load_en) begin
      timer_q  <= load_val;
      waited_q <= 1'b0;
      over_q   <= '0;
    end else begin
      if (tick_hit) timer_q <= count_down(timer_q);
      if (tick_hit && timer_q == '0) over_q <= over_step(over_q);
      if (wait_set) waited_q <= 1'b1;
    end
  end

  assign timer_o  = timer_q;
  assign waited_o = waited_q;
  assign over_o   = over_q;
endmodule

// File: rtl/dtu_resolve.sv
`timescale 1ns/1ps
module dtu_resolve
  import dtu_pkg::*;
#(
  parameter int unsigned TIMER_W = 32,
  parameter int unsigned OVR_W   = 4,
  parameter int unsigned GRACE   = 0
) (
  input  logic               active,
  input  logic [1:0]         op,
  input  logic [TIMER_W-1:0] timer_sel,
  input  logic               waited_sel,
  input  logic [OVR_W-1:0]   over_sel,
  output logic               stall,
  output logic               load_fire,
  output logic               miss_evt,
  output logic               exc_fire
);
  function automatic logic grace_spent(input logic [OVR_W-1:0] n);
    return 32'(n) >= GRACE;
  endfunction

  logic is_branch;
  logic at_zero;

  always_comb begin
    is_branch = (op == DL_BR_IMM) || (op == DL_BR_REG);
    at_zero   = (timer_sel == '0);
    stall     = active && !at_zero;
    load_fire = active && at_zero;
    miss_evt  = load_fire && !waited_sel && grace_spent(over_sel);
    exc_fire  = miss_evt && is_branch;
  end
endmodule

// File: rtl/deadline_timer_unit.sv
`timescale 1ns/1ps
module deadline_timer_unit
  import dtu_pkg::*;
#(
  parameter int unsigned NUM_THREADS = DTU_THREADS,
  parameter int unsigned TID_W       = DTU_TID_W,
  parameter int unsigned TIMER_W     = DTU_TIMER_W,
  parameter int unsigned ADDR_W      = DTU_ADDR_W,
  parameter int unsigned OVR_W       = DTU_OVR_W,
  parameter int unsigned GRACE       = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [TID_W-1:0]   tick_tid,
  input  logic               dl_valid,
  input  logic [TID_W-1:0]   dl_tid,
  input  logic [1:0]         dl_op,
  input  logic [TIMER_W-1:0] dl_imm,
  input  logic [TIMER_W-1:0] dl_reg,
  input  logic [ADDR_W-1:0]  dl_handler,
  output logic               stall,
  output logic               exc_valid,
  output logic [ADDR_W-1:0]  exc_target
);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

  function automatic logic [TIMER_W-1:0] pick_value(input logic [1:0] op,
                                                     input logic [TIMER_W-1:0] imm,
                                                     input logic [TIMER_W-1:0] rv);
    return op[0] ? rv : imm;
  endfunction

  logic [TIMER_W-1:0] timer_w  [NUM_THREADS];
  logic               waited_w [NUM_THREADS];
  logic [OVR_W-1:0]   over_w   [NUM_THREADS];

  logic [NUM_THREADS*TIMER_W-1:0] timers_flat;
  logic [TIMER_W-1:0] load_val;
  logic [TIMER_W-1:0] timer_sel;
  logic               waited_sel;
  logic [OVR_W-1:0]   over_sel;
  logic               tid_ok;
  logic               active;
  logic               load_fire;
  logic               miss_evt;
  logic               exc_fire;

  assign tid_ok   = (dl_tid <= LAST_TID);
  assign active   = dl_valid && tid_ok;
  assign load_val = pick_value(dl_op, dl_imm, dl_reg);

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_slot
    logic hit_self;
    assign hit_self = (dl_tid == TID_W'(i));

    dtu_thread_slot #(.TIMER_W(TIMER_W), .OVR_W(OVR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_hit (tick && (tick_tid == TID_W'(i))),
      .load_en  (load_fire && hit_self),
      .load_val (load_val),
      .wait_set (stall && hit_self),
      .timer_o  (timer_w[i]),
      .waited_o (waited_w[i]),
      .over_o   (over_w[i])
    );

    assign timers_flat[i*TIMER_W +: TIMER_W] = timer_w[i];
  end

  always_comb begin
    timer_sel  = '0;
    waited_sel = 1'b0;
    over_sel   = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (dl_tid == TID_W'(i)) begin
        timer_sel  = timer_w[i];
        waited_sel = waited_w[i];
        over_sel   = over_w[i];
      end
    end
  end

  dtu_resolve #(.TIMER_W(TIMER_W), .OVR_W(OVR_W), .GRACE(GRACE)) u_resolve (
    .active     (active),
    .op         (dl_op),
    .timer_sel  (timer_sel),
    .waited_sel (waited_sel),
    .over_sel   (over_sel),
    .stall      (stall),
    .load_fire  (load_fire),
    .miss_evt   (miss_evt),
    .exc_fire   (exc_fire)
  );

  assign exc_valid  = exc_fire;
  assign exc_target = exc_fire ? dl_handler : '0;
endmodule

// File: rtl/dtu_checker.sv
`timescale 1ns/1ps
module dtu_checker #(
  parameter int unsigned NUM_THREADS = 6,
  parameter int unsigned TID_W       = 3,
  parameter int unsigned TIMER_W     = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           tick,
  input logic [TID_W-1:0]               tick_tid,
  input logic                           dl_valid,
  input logic [TID_W-1:0]               dl_tid,
  input logic [1:0]                     dl_op,
  input logic                           stall,
  input logic                           exc_valid,
  input logic                           load_fire,
  input logic [TIMER_W-1:0]             load_val,
  input logic [NUM_THREADS*TIMER_W-1:0] timers_flat
);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

  function automatic logic [TIMER_W-1:0] timer_at(input logic [NUM_THREADS*TIMER_W-1:0] f,
                                                   input logic [TID_W-1:0] idx);
    logic [TIMER_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (idx == TID_W'(i)) r = f[i*TIMER_W +: TIMER_W];
    return r;
  endfunction

  logic tick_ok;
  logic tick_clash;
  assign tick_ok    = tick && (tick_tid <= LAST_TID);
  assign tick_clash = load_fire && (dl_tid == tick_tid);

  a_r1_stall_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !load_fire);

  a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> timer_at(timers_flat, $past(dl_tid)) == $past(load_val));

  a_r4_tick_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && !tick_clash && timer_at(timers_flat, tick_tid) != '0)
      |=> timer_at(timers_flat, $past(tick_tid)) ==
          $past(timer_at(timers_flat, tick_tid)) - 1'b1);

  a_r4_saturate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && !tick_clash && timer_at(timers_flat, tick_tid) == '0)
      |=> timer_at(timers_flat, $past(tick_tid)) == '0);

  a_r6_exc_needs_branch_completion: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (dl_op[1] && load_fire && !stall));

  a_r8_bad_tid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_valid && dl_tid > LAST_TID) |-> (!stall && !exc_valid && !load_fire));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_valid |-> (!stall && !exc_valid));
endmodule

bind deadline_timer_unit dtu_checker #(
  .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .TIMER_W(TIMER_W)
) u_dtu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .tick_tid    (tick_tid),
  .dl_valid    (dl_valid),
  .dl_tid      (dl_tid),
  .dl_op       (dl_op),
  .stall       (stall),
  .exc_valid   (exc_valid),
  .load_fire   (load_fire),
  .load_val    (load_val),
  .timers_flat (timers_flat)
);

// File: tb/deadline_timer_unit_bench.sv
`timescale 1ns/1ps
module deadline_timer_unit_bench;
  localparam int NT = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [2:0]  tick_tid;
  logic        dl_valid;
  logic [2:0]  dl_tid;
  logic [1:0]  dl_op;
  logic [31:0] dl_imm, dl_reg, dl_handler;
  logic        stall, exc_valid;
  logic [31:0] exc_target;

  always #10 clk = ~clk;

  deadline_timer_unit u_deadline_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tick_tid(tick_tid),
    .dl_valid(dl_valid), .dl_tid(dl_tid), .dl_op(dl_op),
    .dl_imm(dl_imm), .dl_reg(dl_reg), .dl_handler(dl_handler),
    .stall(stall), .exc_valid(exc_valid), .exc_target(exc_target)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state, kept from the requirements
  longint m_timer [NT];
  bit     m_wait  [NT];
  int     m_over  [NT];

  // vector fields: tid(3) op(2) imm(8) reg(8) pre-ticks(8)
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {3'd0, 2'b00, 8'd3,  8'd50, 8'd0},
    {3'd0, 2'b00, 8'd5,  8'd60, 8'd0},
    {3'd1, 2'b01, 8'd99, 8'd4,  8'd0},
    {3'd1, 2'b10, 8'd2,  8'd70, 8'd6},
    {3'd0, 2'b11, 8'd80, 8'd7,  8'd0},
    {3'd2, 2'b10, 8'd1,  8'd0,  8'd0},
    {3'd5, 2'b00, 8'd1,  8'd0,  8'd0},
    {3'd5, 2'b00, 8'd2,  8'd0,  8'd1},
    {3'd5, 2'b11, 8'd0,  8'd9,  8'd2},
    {3'd5, 2'b00, 8'd4,  8'd0,  8'd3}
  };

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    tick = 0; tick_tid = 0; dl_valid = 0; dl_tid = 0; dl_op = 0;
    dl_imm = 0; dl_reg = 0; dl_handler = 0;
  endtask

  // R4: one tick to a thread, no instruction
  task automatic do_tick(input int tid);
    @(negedge clk);
    idle();
    tick = 1; tick_tid = 3'(tid);
    @(posedge clk);
    if (tid < NT) begin
      if (m_timer[tid] == 0) m_over[tid] = (m_over[tid] < 15) ? m_over[tid] + 1 : 15;
      else m_timer[tid]--;
    end
  endtask

  // issue one deadline instruction; replayed each slot while stalled
  task automatic issue(input int tid, input logic [1:0] op, input longint imm,
                       input longint rv, input longint hnd, input string tag);
    bit     e_stall, e_exc;
    longint val;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      idle();
      dl_valid = 1; dl_tid = 3'(tid); dl_op = op;
      dl_imm = 32'(imm); dl_reg = 32'(rv); dl_handler = 32'(hnd);
      tick = 1; tick_tid = 3'(tid);
      #5;
      e_stall = (tid < NT) && (m_timer[tid] != 0);
      e_exc   = (tid < NT) && !e_stall && op[1] && !m_wait[tid] && (m_over[tid] >= 0);
      check({tag, " stall (R1/R2)"}, longint'(stall), longint'(e_stall));
      check({tag, " exc_valid (R6/R7)"}, longint'(exc_valid), longint'(e_exc));
      check({tag, " exc_target (R6)"}, longint'(exc_target), e_exc ? hnd : 0);
      @(posedge clk);
      if (tid < NT) begin
        if (e_stall) begin
          m_wait[tid] = 1;
          m_timer[tid]--;
        end else begin
          val = op[0] ? rv : imm;   // R3 source select, R5 reload beats tick
          m_timer[tid] = val;
          m_wait[tid] = 0;
          m_over[tid] = 0;
        end
      end
      if (!e_stall) break;
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) begin m_timer[i] = 0; m_wait[i] = 0; m_over[i] = 0; end
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #5;
    // R9: quiet after reset
    check("R9 stall idle", longint'(stall), 0);
    check("R9 exc idle", longint'(exc_valid), 0);
    // R9: timers zero, so a plain form completes at once
    issue(3, 2'b00, 2, 0, 32'h500, "R9 reset timer");

    for (int v = 0; v < NV; v++) begin
      int tid; logic [1:0] op; int imm, rv, pre;
      {tid, op, imm, rv, pre} = {29'(0), VEC[v]} ;
      tid = int'(VEC[v][28:26]); op = VEC[v][25:24];
      imm = int'(VEC[v][23:16]); rv = int'(VEC[v][15:8]); pre = int'(VEC[v][7:0]);
      for (int k = 0; k < pre; k++) do_tick(tid);
      issue(tid, op, imm, rv, 32'h1000 + v * 4, $sformatf("vec%0d R3/R4", v));
    end

    // R8: out-of-range ids on both sides leave every thread alone
    issue(7, 2'b10, 3, 3, 32'h2000, "R8 bad tid");
    issue(6, 2'b11, 3, 3, 32'h2004, "R8 bad tid6");
    for (int k = 0; k < 4; k++) do_tick(6 + (k % 2));
    issue(0, 2'b00, 2, 0, 32'h2008, "R8 thread0 after bad ticks");
    issue(3, 2'b00, 1, 0, 32'h200C, "R8 thread3 after bad ticks");

    // R4 saturation then R6 miss on a long-expired timer
    for (int k = 0; k < 5; k++) do_tick(4);
    issue(4, 2'b10, 3, 0, 32'h3000, "R6 miss thread4");
    // R7: waited to zero, branching form raises nothing
    issue(4, 2'b10, 1, 0, 32'h3004, "R7 waited thread4");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule